// File: doc/BRIEF.md
# SPI Controller with Master and Slave Modes

This block is a serial peripheral interface controller that sits on a small processor's register bus. Software sets it up through four byte-addressed registers: control, configuration, clock divider and data. In master mode the block derives the serial clock from the system clock through a programmable divider. It shifts one character out on the master-out line while it shifts one in on the master-in line. In slave mode it follows an external serial clock and a select input whose active level is programmable. It answers on its own slave-out line, and that line's output enable is asserted only while the block is selected.

The data register has two storage locations. A write fills the transmit buffer, and a read returns the receive buffer. In master mode, writing the data register while the block is enabled and idle starts a transfer. At the end of every character a sticky completion flag is set in the control register, and it stays set until software writes 0 to it. An interrupt output follows this flag when the configuration register enables it.

Top module: `spi_ctrl`

## Requirements
- R1: After reset every register reads zero, `sck_o` is 0, `miso_oe_o` is 0 and `irq_o` is 0.
- R2: The registers sit at these offsets: control at 02h, data at 03h, configuration at 0Ah and divider at 0Bh. Control bits 0 (enable) and 1 (master select) read back as written. The configuration byte and the divider byte also read back as written.
- R3: With control = 03h (enabled master) and the block idle, a write to the data register starts a transfer. Data goes out MSB first, and the character is 8 bits when configuration bit 2 is 0.
- R4: In master mode each half period of the serial clock lasts (divider + 1) system clocks, so the serial clock frequency is sysclk / (2·(divider + 1)). A character takes 2·N edges, where N is the character length.
- R5: Control bit 6 is set when a character completes. A control write with bit 6 = 0 clears it. A control write with bit 6 = 1 leaves it unchanged.
- R6: A data register read returns the receive buffer. A data write never changes what a read returns, and while the block is disabled that write starts no transfer.
- R7: Configuration bit 0 (phase) and bit 1 (polarity) select the mode. Polarity sets the idle level of `sck_o`. Phase 0 samples on the leading edge, and phase 1 samples on the trailing edge. The received and sent characters are correct in all four modes.
- R8: When configuration bit 2 is 1, characters are 16 bits long and the whole data register is used.
- R9: In slave mode (control = 01h) with configuration bit 6 = 0, the select input is active low. A full character received on `mosi_i` is stored in the receive buffer. The transmit buffer is shifted out on `miso_o` with `miso_oe_o` high, and the completion flag is set.
- R10: When configuration bit 6 = 1, the select input is active high. A low level on `ss_i` then leaves the block deselected, with `miso_oe_o` low.
- R11: If the select input goes inactive in the middle of a slave character, the shift stops, the completion flag is not set, the receive buffer keeps its previous value and `miso_oe_o` drops. The next full character is received normally.
- R12: `irq_o` equals the completion flag ANDed with configuration bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 8 | Register byte offset |
| bus_we_i | input | 1 | Register write strobe |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for `bus_addr_i` |
| irq_o | output | 1 | Completion interrupt |
| sck_o | output | 1 | Serial clock in master mode |
| mosi_o | output | 1 | Serial data out in master mode |
| miso_i | input | 1 | Serial data in for master mode |
| sck_i | input | 1 | Serial clock in slave mode |
| ss_i | input | 1 | Slave select, polarity set by configuration |
| mosi_i | input | 1 | Serial data in for slave mode |
| miso_o | output | 1 | Serial data out in slave mode |
| miso_oe_o | output | 1 | Output enable for `miso_o` |

## Verification
The hardest case to reach is a slave character cut short by the select input. The bench plays the external master bit by bit on `sck_i`, `mosi_i` and `ss_i`. It releases select after three bits, then checks that the flag stays clear, that the receive buffer holds the previous character and that the output enable has dropped. A full character follows straight after to show that the shifter recovered. The master modes run from a vector table against a behavioural slave that watches `sck_o`. That slave checks the half-period timing, the edge count and both data directions for each combination of phase, polarity, width and divider.

// File: rtl/spi_ctrl_pkg.sv
package spi_ctrl_pkg;
  localparam logic [7:0] ADR_CTL = 8'h02;
  localparam logic [7:0] ADR_DAT = 8'h03;
  localparam logic [7:0] ADR_CFG = 8'h0A;
  localparam logic [7:0] ADR_DIV = 8'h0B;

  localparam int CTL_EN   = 0;
  localparam int CTL_MST  = 1;
  localparam int CTL_DONE = 6;

  localparam int CFG_CPHA  = 0;
  localparam int CFG_CPOL  = 1;
  localparam int CFG_WIDE  = 2;
  localparam int CFG_SSHI  = 6;
  localparam int CFG_IRQEN = 7;

  typedef struct packed {
    logic ss_hi;
    logic wide;
    logic cpol;
    logic cpha;
  } cfg_t;
endpackage

// File: rtl/spi_ctrl_sync.sv
module spi_ctrl_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/spi_ctrl_regs.sv
module spi_ctrl_regs
  import spi_ctrl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              en_o,
  output logic              mst_o,
  output cfg_t              cfg_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [DATA_W-1:0] tx_o,
  output logic              start_o,
  output logic              done_o,
  output logic              irq_o,
  input  logic              busy_i,
  input  logic              xfer_done_i,
  input  logic [DATA_W-1:0] rx_i
);
  logic              en_q, mst_q, done_q;
  logic [7:0]        cfg_q;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] tx_q, rx_q;
  logic wr_ctl, wr_dat, wr_cfg, wr_div;

  assign wr_ctl = we_i && (addr_i == ADR_CTL);
  assign wr_dat = we_i && (addr_i == ADR_DAT);
  assign wr_cfg = we_i && (addr_i == ADR_CFG);
  assign wr_div = we_i && (addr_i == ADR_DIV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mst_q  <= 1'b0;
      done_q <= 1'b0;
      cfg_q  <= '0;
      div_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      if (wr_ctl) begin
        en_q  <= wdata_i[CTL_EN];
        mst_q <= wdata_i[CTL_MST];
      end
      if (wr_cfg) cfg_q <= wdata_i[7:0];
      if (wr_div) div_q <= wdata_i[DIV_W-1:0];
      if (wr_dat) tx_q <= wdata_i;
      if (xfer_done_i) rx_q <= rx_i;
      // hardware set wins over a same-cycle software clear
      if (xfer_done_i) done_q <= 1'b1;
      else if (wr_ctl && !wdata_i[CTL_DONE]) done_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADR_CTL: begin
        rdata_o[CTL_EN]   = en_q;
        rdata_o[CTL_MST]  = mst_q;
        rdata_o[CTL_DONE] = done_q;
      end
      ADR_DAT: rdata_o = rx_q;
      ADR_CFG: rdata_o[7:0] = cfg_q;
      ADR_DIV: rdata_o[DIV_W-1:0] = div_q;
      default: rdata_o = '0;
    endcase
  end

  assign cfg_o.cpha  = cfg_q[CFG_CPHA];
  assign cfg_o.cpol  = cfg_q[CFG_CPOL];
  assign cfg_o.wide  = cfg_q[CFG_WIDE];
  assign cfg_o.ss_hi = cfg_q[CFG_SSHI];

  assign en_o    = en_q;
  assign mst_o   = mst_q;
  assign div_o   = div_q;
  assign tx_o    = tx_q;
  assign done_o  = done_q;
  assign start_o = wr_dat && en_q && mst_q && !busy_i;
  assign irq_o   = done_q && cfg_q[CFG_IRQEN];
endmodule

// File: rtl/spi_ctrl_clkgen.sv
module spi_ctrl_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!run_i || cnt_q == div_i) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  // one tick per half period of the serial clock
  assign tick_o = run_i && (cnt_q == div_i);
endmodule

// File: rtl/spi_ctrl_shift.sv
module spi_ctrl_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              mst_i,
  input  logic              cpha_i,
  input  logic              cpol_i,
  input  logic              wide_i,
  input  logic              start_i,
  input  logic              tick_i,
  input  logic [DATA_W-1:0] ld_mst_i,
  input  logic [DATA_W-1:0] ld_slv_i,
  input  logic              sck_s_i,
  input  logic              ss_act_i,
  input  logic              sdi_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o,
  output logic              sdo_o,
  output logic              ph_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam int CW     = $clog2(2 * DATA_W);

  logic              busy_q, ph_q, sdo_q, sck_prev_q;
  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] tx_sr_q, rx_sr_q;
  logic              edge_ev, lead, smp, drv, last;
  logic [DATA_W-1:0] rx_nxt, ld_src, ld_al, tx_ld;

  always_comb begin
    edge_ev = busy_q && (mst_i ? tick_i : (sck_s_i != sck_prev_q));
    lead    = mst_i ? !ph_q : (sck_s_i != cpol_i);
    smp     = edge_ev && (lead != cpha_i);
    drv     = edge_ev && !smp;
    last    = edge_ev && (cnt_q == (wide_i ? CW'(2*DATA_W-1) : CW'(2*HALF_W-1)));
    rx_nxt  = smp ? {rx_sr_q[DATA_W-2:0], sdi_i} : rx_sr_q;
    ld_src  = mst_i ? ld_mst_i : ld_slv_i;
    ld_al   = wide_i ? ld_src : {ld_src[HALF_W-1:0], {HALF_W{1'b0}}};
    // phase 0 presents the first bit before the first edge
    tx_ld   = cpha_i ? ld_al : (ld_al << 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      ph_q       <= 1'b0;
      sdo_q      <= 1'b0;
      sck_prev_q <= 1'b0;
      cnt_q      <= '0;
      tx_sr_q    <= '0;
      rx_sr_q    <= '0;
    end else begin
      sck_prev_q <= sck_s_i;
      if (!en_i) begin
        busy_q <= 1'b0;
        ph_q   <= 1'b0;
      end else if (!busy_q) begin
        if (mst_i ? start_i : ss_act_i) begin
          busy_q  <= 1'b1;
          ph_q    <= 1'b0;
          cnt_q   <= '0;
          rx_sr_q <= '0;
          tx_sr_q <= tx_ld;
          if (!cpha_i) sdo_q <= ld_al[DATA_W-1];
        end
      end else if (!mst_i && !ss_act_i) begin
        busy_q <= 1'b0;  // select released mid-character
      end else if (edge_ev) begin
        ph_q    <= ~ph_q;
        cnt_q   <= cnt_q + 1'b1;
        rx_sr_q <= rx_nxt;
        if (drv) begin
          sdo_q   <= tx_sr_q[DATA_W-1];
          tx_sr_q <= tx_sr_q << 1;
        end
        if (last) begin
          cnt_q <= '0;
          ph_q  <= 1'b0;
          if (mst_i) begin
            busy_q <= 1'b0;
          end else begin
            rx_sr_q <= '0;
            tx_sr_q <= tx_ld;
            if (!cpha_i) sdo_q <= ld_al[DATA_W-1];
          end
        end
      end
    end
  end

  assign done_o = en_i && last && (mst_i || ss_act_i);
  assign rx_o   = wide_i ? rx_nxt : {{HALF_W{1'b0}}, rx_nxt[HALF_W-1:0]};
  assign busy_o = busy_q;
  assign sdo_o  = sdo_q;
  assign ph_o   = ph_q;
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_ctrl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        bus_addr_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  input  logic              sck_i,
  input  logic              ss_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe_o
);
  logic              en, mst, start, tick, busy, xfer_done, done_flag, sdo, ph;
  logic              sck_s, ss_s, mosi_s, ss_act, sdi;
  cfg_t              cfg;
  logic [DIV_W-1:0]  div;
  logic [DATA_W-1:0] tx_buf, rx_data;

  spi_ctrl_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (bus_addr_i),
    .we_i        (bus_we_i),
    .wdata_i     (bus_wdata_i),
    .rdata_o     (bus_rdata_o),
    .en_o        (en),
    .mst_o       (mst),
    .cfg_o       (cfg),
    .div_o       (div),
    .tx_o        (tx_buf),
    .start_o     (start),
    .done_o      (done_flag),
    .irq_o       (irq_o),
    .busy_i      (busy),
    .xfer_done_i (xfer_done),
    .rx_i        (rx_data)
  );

  spi_ctrl_sync #(.W(3)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sck_i, ss_i, mosi_i}),
    .q_o    ({sck_s, ss_s, mosi_s})
  );

  spi_ctrl_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy && mst),
    .div_i  (div),
    .tick_o (tick)
  );

  assign ss_act = (ss_s == cfg.ss_hi);
  assign sdi    = mst ? miso_i : mosi_s;

  spi_ctrl_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en),
    .mst_i    (mst),
    .cpha_i   (cfg.cpha),
    .cpol_i   (cfg.cpol),
    .wide_i   (cfg.wide),
    .start_i  (start),
    .tick_i   (tick),
    .ld_mst_i (bus_wdata_i),
    .ld_slv_i (tx_buf),
    .sck_s_i  (sck_s),
    .ss_act_i (ss_act),
    .sdi_i    (sdi),
    .busy_o   (busy),
    .done_o   (xfer_done),
    .rx_o     (rx_data),
    .sdo_o    (sdo),
    .ph_o     (ph)
  );

  assign sck_o     = cfg.cpol ^ ph;
  assign mosi_o    = (en && mst) ? sdo : 1'b0;
  assign miso_oe_o = en && !mst && ss_act;
  assign miso_o    = miso_oe_o ? sdo : 1'b0;
endmodule

// File: rtl/spi_ctrl_chk.sv
module spi_ctrl_chk
  import spi_ctrl_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bus_we_i,
  input logic [7:0] bus_addr_i,
  input logic       clr_bit_i,
  input logic       busy_i,
  input logic       tick_i,
  input logic       en_i,
  input logic       mst_i,
  input logic       done_i,
  input logic       irq_i,
  input logic       sck_i,
  input logic       miso_oe_i
);
  // R5
  done_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> $past(busy_i));

  // R5
  done_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_i) |-> $past(bus_we_i && bus_addr_i == ADR_CTL && !clr_bit_i));

  // R12
  irq_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> done_i);

  // R11
  miso_oe_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miso_oe_i |-> (en_i && !mst_i));

  // R4
  sck_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && mst_i && !tick_i && !bus_we_i) |=> $stable(sck_i));

  // R3
  sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !bus_we_i) |=> $stable(sck_i));
endmodule

bind spi_ctrl spi_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .clr_bit_i  (bus_wdata_i[6]),
  .busy_i     (busy),
  .tick_i     (tick),
  .en_i       (en),
  .mst_i      (mst),
  .done_i     (done_flag),
  .irq_i      (irq_o),
  .sck_i      (sck_o),
  .miso_oe_i  (miso_oe_o)
);

// File: tb/tb_spi_ctrl.sv
`timescale 1ns/1ps
module tb_spi_ctrl;
  localparam logic [7:0] A_CTL = 8'h02, A_DAT = 8'h03, A_CFG = 8'h0A, A_DIV = 8'h0B;
  localparam int NV = 9;
  // cfg, div, tx, slave reply
  localparam logic [47:0] VEC [NV] = '{
    {8'h00, 8'h03, 16'h0012, 16'h00A5},
    {8'h00, 8'h3F, 16'h0034, 16'h003C},
    {8'h00, 8'h01, 16'hAB12, 16'h0066},
    {8'h01, 8'h02, 16'h00C3, 16'h0081},
    {8'h02, 8'h01, 16'h0096, 16'h007E},
    {8'h03, 8'h04, 16'h00F0, 16'h000F},
    {8'h04, 8'h02, 16'h1234, 16'hBEEF},
    {8'h07, 8'h01, 16'hA55A, 16'h0F0F},
    {8'h80, 8'h02, 16'h0055, 16'h00AA}
  };

  logic clk = 0, rst_n = 0;
  logic [7:0]  bus_addr = 0;
  logic        bus_we = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic irq, sck_o, mosi_o, miso_i, miso_o, miso_oe;
  logic sck_i = 0, ss_i = 1, mosi_i = 0;

  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  spi_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_addr_i(bus_addr), .bus_we_i(bus_we), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .irq_o(irq),
    .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i),
    .sck_i(sck_i), .ss_i(ss_i), .mosi_i(mosi_i),
    .miso_o(miso_o), .miso_oe_o(miso_oe)
  );

  // behavioural slave attached to the master pins
  logic        mdl_on = 0, m_cpol = 0, m_cpha = 0;
  logic [15:0] m_init = 0;
  logic        was_on = 0;
  logic [15:0] s_out, s_in;
  int          n_edges;
  longint      t_first, t_half;

  always @(sck_o or mdl_on) begin
    if (!mdl_on) begin
      was_on = 0;
    end else if (!was_on) begin
      was_on  = 1;
      s_out   = m_init;
      s_in    = 0;
      n_edges = 0;
      t_half  = 0;
      miso_i  = m_init[15];
    end else begin
      n_edges++;
      if (n_edges == 1) t_first = $time;
      if (n_edges == 2) t_half = $time - t_first;
      if ((sck_o != m_cpol) != m_cpha) s_in = {s_in[14:0], mosi_o};
      else if (m_cpha) begin miso_i = s_out[15]; s_out = s_out << 1; end
      else begin s_out = s_out << 1; miso_i = s_out[15]; end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_done(output logic ok);
    logic [15:0] v;
    ok = 0;
    for (int k = 0; k < 20000 && !ok; k++) begin
      bus_rd(A_CTL, v);
      ok = v[6];
    end
  endtask

  // plays an external master, mode 0, 8 bits; nb < 8 cuts the character short
  task automatic slv_xfer(input logic [7:0] tx, input int nb, input logic act,
                          output logic [7:0] cap, output logic oe_seen);
    cap = 0; oe_seen = 0;
    @(negedge clk); ss_i = act;
    for (int b = 0; b < nb; b++) begin
      mosi_i = tx[7-b];
      repeat (8) @(negedge clk);
      cap = {cap[6:0], miso_o};
      if (b == 0) oe_seen = miso_oe;
      sck_i = 1;
      repeat (8) @(negedge clk);
      sck_i = 0;
    end
    repeat (8) @(negedge clk);
    ss_i = !act;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] v, rx_last;
    logic        ok, oe;
    logic [7:0]  cap;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    bus_rd(A_CTL, v); chk("R1 ctl", v, 0);
    bus_rd(A_CFG, v); chk("R1 cfg", v, 0);
    bus_rd(A_DIV, v); chk("R1 div", v, 0);
    bus_rd(A_DAT, v); chk("R1 dat", v, 0);
    chk("R1 pins", {sck_o, miso_oe, irq}, 0);

    // R2 map and readback
    bus_wr(A_CTL, 16'h0002); bus_rd(A_CTL, v); chk("R2 ctl", v, 16'h0002);
    bus_wr(A_CFG, 16'h0038); bus_rd(A_CFG, v); chk("R2 cfg", v, 16'h0038);
    bus_wr(A_DIV, 16'h00C3); bus_rd(A_DIV, v); chk("R2 div", v, 16'h00C3);
    bus_wr(A_CFG, 0); bus_wr(A_DIV, 0);

    // master modes from the vector table
    for (int i = 0; i < NV; i++) begin
      logic [7:0]  cf, dv;
      logic [15:0] tx, rs, msk;
      int          nb;
      string       tag;
      cf = VEC[i][47:40]; dv = VEC[i][39:32]; tx = VEC[i][31:16]; rs = VEC[i][15:0];
      nb  = cf[2] ? 16 : 8;
      msk = cf[2] ? 16'hFFFF : 16'h00FF;
      tag = cf[2] ? "R8" : (cf[1:0] != 0 ? "R7" : "R3");
      bus_wr(A_CTL, 16'h0003);
      bus_wr(A_CFG, {8'h00, cf});
      bus_wr(A_DIV, {8'h00, dv});
      @(negedge clk);
      chk("R7 idle level", sck_o, cf[1]);
      m_cpol = cf[1]; m_cpha = cf[0];
      m_init = cf[2] ? rs : {rs[7:0], 8'h00};
      mdl_on = 1;
      bus_wr(A_DAT, tx);
      wait_done(ok);
      chk("R5 done set", ok, 1);
      chk({tag, " mosi"}, s_in & msk, tx & msk);
      bus_rd(A_DAT, v); chk({tag, " rx"}, v, rs & msk);
      rx_last = rs & msk;
      chk("R4 half period", t_half, (dv + 1) * 4);
      chk("R4 edges", n_edges, 2 * nb);
      chk("R12 irq", irq, cf[7]);
      mdl_on = 0;
      if (i == 0) begin
        bus_wr(A_CTL, 16'h0043);
        bus_rd(A_CTL, v); chk("R5 write one keeps", v[6], 1);
      end
      bus_wr(A_CTL, 16'h0003);
      bus_rd(A_CTL, v); chk("R5 cleared", v[6], 0);
      chk("R12 irq low", irq, 0);
      if (i == 0) begin
        bus_wr(A_CTL, 16'h0043);
        bus_rd(A_CTL, v); chk("R5 write one no set", v[6], 0);
      end
    end

    // R6 data write while disabled
    bus_wr(A_CFG, 0);
    bus_wr(A_CTL, 0);
    bus_wr(A_DAT, 16'h5A5A);
    repeat (20) @(negedge clk);
    bus_rd(A_DAT, v); chk("R6 read is rx", v, rx_last);
    bus_rd(A_CTL, v); chk("R6 no start", v[6], 0);
    chk("R6 sck idle", sck_o, 0);

    // R9 slave, active-low select
    bus_wr(A_CTL, 16'h0001);
    bus_wr(A_DAT, 16'h00C6);
    repeat (4) @(negedge clk);
    chk("R9 oe idle", miso_oe, 0);
    slv_xfer(8'h3B, 8, 1'b0, cap, oe);
    chk("R9 oe selected", oe, 1);
    chk("R9 miso", cap, 8'hC6);
    bus_rd(A_DAT, v); chk("R9 rx", v, 16'h003B);
    bus_rd(A_CTL, v); chk("R9 done", v[6], 1);
    bus_wr(A_CTL, 16'h0001);

    // R10 active-high select
    bus_wr(A_CTL, 0);
    bus_wr(A_CFG, 16'h0040);
    ss_i = 0;
    repeat (4) @(negedge clk);
    bus_wr(A_CTL, 16'h0001);
    bus_wr(A_DAT, 16'h0071);
    repeat (4) @(negedge clk);
    chk("R10 low is idle", miso_oe, 0);
    slv_xfer(8'hE4, 8, 1'b1, cap, oe);
    chk("R10 oe selected", oe, 1);
    chk("R10 miso", cap, 8'h71);
    bus_rd(A_DAT, v); chk("R10 rx", v, 16'h00E4);
    bus_rd(A_CTL, v); chk("R10 done", v[6], 1);
    bus_wr(A_CTL, 16'h0001);

    // R11 abort mid-character
    slv_xfer(8'hFF, 3, 1'b1, cap, oe);
    bus_rd(A_CTL, v); chk("R11 no done", v[6], 0);
    chk("R11 oe dropped", miso_oe, 0);
    bus_rd(A_DAT, v); chk("R11 rx kept", v, 16'h00E4);
    slv_xfer(8'h96, 8, 1'b1, cap, oe);
    bus_rd(A_DAT, v); chk("R11 recovers", v, 16'h0096);
    bus_rd(A_CTL, v); chk("R11 done after recovery", v[6], 1);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule